// File: doc/BRIEF.md
# Serial Memory SPI Command Front-End

This block is the slave side of a four-wire serial link for a byte-addressed non-volatile store of 32 Kbytes, arranged as pages of 64 bytes. The select, clock, data-in and hold lines are brought into a fast system clock through synchronisers. The block then cuts the bit stream into an opcode, a two-byte address and data bytes. It answers reads by streaming bytes from a memory read port and buffers page writes. It commits a buffered write to the memory write port only when the deselect falls exactly on a byte boundary.

The serial clock may idle low or high, so both clock modes 0 and 3 work. A hold input pauses a transfer without losing its place. A select line that is already low when reset ends cannot open a transaction. A write cycle keeps the block busy for a set number of system clocks. During that time, only status reads are served.

The memory read port gives the read address. The array must return the byte on `mem_rd_data` within one system clock. Each serial clock half-period must span at least six system clocks.

Top module: `spi_mem_frontend`

## Requirements
- R1: After reset `spi_miso_oe` is low, no write is issued and the status byte reads 00h. A select that is low during reset opens no transaction until it has been seen high and then low.
- R2: Data-in is captured on serial clock rising edges and data-out changes after falling edges, both MSB first. Clock idle low (mode 0) and idle high (mode 3) both work.
- R3: Opcode 06h sets the write-enable latch and opcode 04h clears it, each once its opcode byte is complete.
- R4: Opcode 05h returns the status byte {bit7 lock flag, bits 6:4 zero, bits 3:2 protect field, bit1 write-enable latch, bit0 busy}, repeated for as long as select stays low.
- R5: Opcode 03h followed by two address bytes streams bytes from that address (bit 7 of the first address byte is ignored), incrementing after each byte and wrapping from 7FFFh to 0000h.
- R6: Opcode 02h with the latch set buffers data bytes at an address that increments and wraps inside its 64-byte page. On commit, each written offset is issued once on the write port, in ascending offset order.
- R7: A write-type command commits only if select rises on a byte boundary after at least one data byte. Otherwise nothing is written and the latch is unchanged.
- R8: A write-type opcode (02h or 01h) received while the latch is clear is ignored.
- R9: Opcode 01h with the latch set stores bit 7 and bits 3:2 of the first data byte into the status byte. Later data bytes are ignored.
- R10: After a commit the busy bit is set for TW_CYCLES system clocks, with the latch still set. Only opcode 05h is decoded meanwhile, and at the end both bits clear.
- R11: Hold low with the serial clock low pauses the transfer: data-out is disabled and clock edges are ignored. The transfer resumes when hold is high and the clock is low.
- R12: Raising select while the transfer is held discards it.
- R13: An unknown opcode makes the rest of the transaction ignored, with no output, until select rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| spi_csn | input | 1 | Serial select, active low |
| spi_sck | input | 1 | Serial clock |
| spi_mosi | input | 1 | Serial data into the block |
| spi_holdn | input | 1 | Pause request, active low |
| spi_miso | output | 1 | Serial data out of the block |
| spi_miso_oe | output | 1 | Output enable for spi_miso |
| mem_rd_addr | output | 15 | Array read address |
| mem_rd_data | input | 8 | Array read data, valid one clock after the address |
| mem_wr_en | output | 1 | Array write strobe, one byte per clock |
| mem_wr_addr | output | 15 | Array write address |
| mem_wr_data | output | 8 | Array write data |

## Verification
A wrong bit counter or phase shows up within one byte as a shifted or wrong status or read byte at the master. Bad framing state shows up after the deselect, as writes that appear, go missing or come out in the wrong order on the write port within about 70 clocks. A stuck busy or latch bit is seen at the next status read, and a hold flag stuck on shows as an output enable that never comes back.

// File: rtl/spimem_pkg.sv
package spimem_pkg;

    typedef enum logic [3:0] {
        PH_IDLE,
        PH_CMD,
        PH_AHI,
        PH_ALO,
        PH_WDATA,
        PH_RDATA,
        PH_STAT,
        PH_WSTAT,
        PH_SKIP
    } phase_e;

    localparam logic [7:0] OP_WREN  = 8'h06;
    localparam logic [7:0] OP_WRDI  = 8'h04;
    localparam logic [7:0] OP_RDSR  = 8'h05;
    localparam logic [7:0] OP_WRSR  = 8'h01;
    localparam logic [7:0] OP_READ  = 8'h03;
    localparam logic [7:0] OP_WRITE = 8'h02;

    function automatic logic [7:0] status_byte(input logic lock, input logic [1:0] prot,
                                               input logic wel, input logic busy);
        return {lock, 3'b000, prot, wel, busy};
    endfunction

endpackage

// File: rtl/spimem_sync.sv
module spimem_sync #(
    parameter int               WIDTH   = 4,
    parameter int               STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [STAGES-1:0][WIDTH-1:0] stg;

    always_ff @(posedge clk) begin
        if (rst) begin
            stg <= {STAGES{RST_VAL}};
        end else begin
            stg[0] <= d;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/spimem_pagebuf.sv
module spimem_pagebuf #(
    parameter int ADDR_W = 15,
    parameter int PAGE_W = 6,
    parameter int DATA_W = 8
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     clear,
    input  logic                     wr_en,
    input  logic [PAGE_W-1:0]        wr_off,
    input  logic [DATA_W-1:0]        wr_data,
    input  logic                     drain_go,
    input  logic [ADDR_W-PAGE_W-1:0] drain_page,
    output logic                     out_en,
    output logic [ADDR_W-1:0]        out_addr,
    output logic [DATA_W-1:0]        out_data
);
    localparam int DEPTH = 1 << PAGE_W;

    logic [DATA_W-1:0]        store [DEPTH];
    logic [DEPTH-1:0]         valid;
    logic                     active;
    logic [PAGE_W-1:0]        idx;
    logic [ADDR_W-PAGE_W-1:0] page_q;

    always_ff @(posedge clk) begin
        if (wr_en) store[wr_off] <= wr_data;
    end

    always_ff @(posedge clk) begin
        if (rst || clear) valid <= '0;
        else if (wr_en)   valid[wr_off] <= 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            active   <= 1'b0;
            idx      <= '0;
            page_q   <= '0;
            out_en   <= 1'b0;
            out_addr <= '0;
            out_data <= '0;
        end else begin
            out_en <= 1'b0;
            if (drain_go) begin
                active <= 1'b1;
                idx    <= '0;
                page_q <= drain_page;
            end else if (active) begin
                out_en   <= valid[idx];
                out_addr <= {page_q, idx};
                out_data <= store[idx];
                idx      <= idx + PAGE_W'(1);
                if (idx == PAGE_W'(DEPTH - 1)) active <= 1'b0;
            end
        end
    end

    AST_DRAIN_NO_FILL: assert property (@(posedge clk) disable iff (rst) active |-> !(wr_en || clear)) else $error("buffer touched while draining"); // R10
endmodule

// File: rtl/spi_mem_frontend.sv
module spi_mem_frontend
    import spimem_pkg::*;
#(
    parameter int ADDR_W      = 15,
    parameter int PAGE_W      = 6,
    parameter int TW_CYCLES   = 2000,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              spi_csn,
    input  logic              spi_sck,
    input  logic              spi_mosi,
    input  logic              spi_holdn,
    output logic              spi_miso,
    output logic              spi_miso_oe,
    output logic [ADDR_W-1:0] mem_rd_addr,
    input  logic [7:0]        mem_rd_data,
    output logic              mem_wr_en,
    output logic [ADDR_W-1:0] mem_wr_addr,
    output logic [7:0]        mem_wr_data
);
    localparam int TW_W = $clog2(TW_CYCLES + 1);

    // synchronised pins; select resets low so a low line at boot is no edge
    logic csn_s, sck_s, mosi_s, holdn_s;
    spimem_sync #(.WIDTH(4), .STAGES(SYNC_STAGES), .RST_VAL(4'b0001)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   ({spi_csn, spi_sck, spi_mosi, spi_holdn}),
        .q   ({csn_s, sck_s, mosi_s, holdn_s})
    );

    logic csn_q, sck_q;
    always_ff @(posedge clk) begin
        if (rst) begin
            csn_q <= 1'b0;
            sck_q <= 1'b0;
        end else begin
            csn_q <= csn_s;
            sck_q <= sck_s;
        end
    end

    logic cs_start, cs_end, sck_rise, sck_fall;
    assign cs_start = csn_q & ~csn_s;
    assign cs_end   = ~csn_q & csn_s;
    assign sck_rise = sck_s & ~sck_q;
    assign sck_fall = ~sck_s & sck_q;

    logic selected, held, boot_hi;
    always_ff @(posedge clk) begin
        if (rst) begin
            selected <= 1'b0;
            boot_hi  <= 1'b0;
        end else begin
            if (csn_s) boot_hi <= 1'b1;
            if (cs_end)        selected <= 1'b0;
            else if (cs_start) selected <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || csn_s)                  held <= 1'b0;
        else if (!held && !holdn_s && !sck_s) held <= 1'b1;
        else if (held && holdn_s && !sck_s)   held <= 1'b0;
    end

    logic live;
    assign live = selected & ~held & ~csn_s;

    // transaction state
    phase_e            phase;
    logic [2:0]        bit_cnt;
    logic [7:0]        rx_sh;
    logic [ADDR_W-1:0] addr;
    logic              is_read, have_data, wsr_lock;
    logic [1:0]        wsr_prot;
    logic [6:0]        tx_sh;
    logic              miso_q, tx_live;

    // status
    logic            lock_q, wel, wip;
    logic [1:0]      prot_q;
    logic [TW_W-1:0] tw_cnt;

    logic [7:0] rx_next, tx_src;
    logic       byte_done, out_phase, commit_ok, commit_page, commit_stat;
    logic       dec_wren, dec_wrdi;

    assign rx_next   = {rx_sh[6:0], mosi_s};
    assign byte_done = live & sck_rise & (phase != PH_IDLE) & (bit_cnt == 3'd7);
    assign out_phase = (phase == PH_RDATA) || (phase == PH_STAT);
    assign tx_src    = (phase == PH_STAT) ? status_byte(lock_q, prot_q, wel, wip) : mem_rd_data;
    assign dec_wren  = byte_done & (phase == PH_CMD) & ~wip & (rx_next == OP_WREN);
    assign dec_wrdi  = byte_done & (phase == PH_CMD) & ~wip & (rx_next == OP_WRDI);
    assign commit_ok   = cs_end & selected & ~held & (bit_cnt == 3'd0) & have_data;
    assign commit_page = commit_ok & (phase == PH_WDATA);
    assign commit_stat = commit_ok & (phase == PH_WSTAT);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase     <= PH_IDLE;
            bit_cnt   <= '0;
            rx_sh     <= '0;
            addr      <= '0;
            is_read   <= 1'b0;
            have_data <= 1'b0;
            wsr_lock  <= 1'b0;
            wsr_prot  <= '0;
            tx_sh     <= '0;
            miso_q    <= 1'b0;
            tx_live   <= 1'b0;
        end else if (cs_start) begin
            phase     <= PH_CMD;
            bit_cnt   <= '0;
            have_data <= 1'b0;
            tx_live   <= 1'b0;
        end else if (cs_end) begin
            phase   <= PH_IDLE;
            tx_live <= 1'b0;
        end else if (live && sck_rise && phase != PH_IDLE) begin
            bit_cnt <= bit_cnt + 3'd1;
            rx_sh   <= rx_next;
            if (bit_cnt == 3'd7) begin
                unique case (phase)
                    PH_CMD: begin
                        if (wip && rx_next != OP_RDSR) phase <= PH_SKIP;
                        else begin
                            unique case (rx_next)
                                OP_RDSR:  phase <= PH_STAT;
                                OP_WRSR:  phase <= wel ? PH_WSTAT : PH_SKIP;
                                OP_READ:  begin phase <= PH_AHI; is_read <= 1'b1; end
                                OP_WRITE: begin phase <= wel ? PH_AHI : PH_SKIP; is_read <= 1'b0; end
                                default:  phase <= PH_SKIP;
                            endcase
                        end
                    end
                    PH_AHI: begin
                        addr[ADDR_W-1:8] <= rx_next[ADDR_W-9:0];
                        phase <= PH_ALO;
                    end
                    PH_ALO: begin
                        addr[7:0] <= rx_next;
                        phase     <= is_read ? PH_RDATA : PH_WDATA;
                    end
                    PH_WDATA: begin
                        addr[PAGE_W-1:0] <= addr[PAGE_W-1:0] + PAGE_W'(1);
                        have_data        <= 1'b1;
                    end
                    PH_RDATA: addr <= addr + ADDR_W'(1);
                    PH_WSTAT: begin
                        if (!have_data) begin
                            wsr_lock <= rx_next[7];
                            wsr_prot <= rx_next[3:2];
                        end
                        have_data <= 1'b1;
                    end
                    default: ;
                endcase
            end
        end else if (live && sck_fall && out_phase) begin
            tx_live <= 1'b1;
            if (bit_cnt == 3'd0) begin
                miso_q <= tx_src[7];
                tx_sh  <= tx_src[6:0];
            end else begin
                miso_q <= tx_sh[6];
                tx_sh  <= {tx_sh[5:0], 1'b0};
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wel    <= 1'b0;
            wip    <= 1'b0;
            tw_cnt <= '0;
            lock_q <= 1'b0;
            prot_q <= '0;
        end else if (commit_page || commit_stat) begin
            wip    <= 1'b1;
            tw_cnt <= TW_W'(TW_CYCLES);
            if (commit_stat) begin
                lock_q <= wsr_lock;
                prot_q <= wsr_prot;
            end
        end else if (wip) begin
            tw_cnt <= tw_cnt - TW_W'(1);
            if (tw_cnt == TW_W'(1)) begin
                wip <= 1'b0;
                wel <= 1'b0;
            end
        end else if (dec_wren) begin
            wel <= 1'b1;
        end else if (dec_wrdi) begin
            wel <= 1'b0;
        end
    end

    spimem_pagebuf #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .DATA_W(8)) u_pagebuf (
        .clk        (clk),
        .rst        (rst),
        .clear      (byte_done & (phase == PH_ALO) & ~is_read),
        .wr_en      (byte_done & (phase == PH_WDATA)),
        .wr_off     (addr[PAGE_W-1:0]),
        .wr_data    (rx_next),
        .drain_go   (commit_page),
        .drain_page (addr[ADDR_W-1:PAGE_W]),
        .out_en     (mem_wr_en),
        .out_addr   (mem_wr_addr),
        .out_data   (mem_wr_data)
    );

    assign spi_miso    = miso_q;
    assign spi_miso_oe = selected & ~held & ~csn_s & tx_live;
    assign mem_rd_addr = addr;

    AST_BOOT_GUARD: assert property (@(posedge clk) disable iff (rst) selected |-> boot_hi) else $error("selected without prior high select"); // R1
    AST_COMMIT_AT_DESELECT: assert property (@(posedge clk) disable iff (rst) $rose(wip) |-> $past(csn_s)) else $error("busy began while selected"); // R7
    AST_BUSY_END_DROPS_WEL: assert property (@(posedge clk) disable iff (rst) $fell(wip) |-> !wel) else $error("latch left set after busy"); // R10
    AST_HOLD_QUIET: assert property (@(posedge clk) disable iff (rst) held |-> !spi_miso_oe) else $error("output enabled while held"); // R11
    AST_WRITE_ONLY_BUSY: assert property (@(posedge clk) disable iff (rst) mem_wr_en |-> wip) else $error("array write outside busy window"); // R6
endmodule

// File: tb/spi_mem_frontend_bench.sv
module spi_mem_frontend_bench;
    localparam int TW   = 2000;
    localparam int HALF = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #10 clk = ~clk;

    logic csn, sck, mosi, holdn;
    logic miso, miso_oe, wr_en;
    logic [14:0] rd_addr, wr_addr;
    logic [7:0]  rdq, wr_data;

    spi_mem_frontend #(.TW_CYCLES(TW)) u_spi_mem_frontend (
        .clk(clk), .rst(rst), .spi_csn(csn), .spi_sck(sck), .spi_mosi(mosi),
        .spi_holdn(holdn), .spi_miso(miso), .spi_miso_oe(miso_oe),
        .mem_rd_addr(rd_addr), .mem_rd_data(rdq), .mem_wr_en(wr_en),
        .mem_wr_addr(wr_addr), .mem_wr_data(wr_data)
    );

    int total = 0;
    int bad = 0;
    bit mode3 = 1'b0;
    logic [7:0] wmem [int];
    int         act_a [$];
    logic [7:0] act_d [$];
    int oe_cnt = 0;
    int act_ptr = 0;

    function automatic logic [7:0] pat(input int a);
        return 8'((a * 37 + 11) ^ (a >> 7));
    endfunction

    function automatic logic [7:0] model_rd(input int a);
        if (wmem.exists(a)) return wmem[a];
        return pat(a);
    endfunction

    always @(posedge clk) rdq <= model_rd(int'(rd_addr));

    always @(negedge clk) begin
        if (miso_oe) oe_cnt++;
        if (wr_en) begin
            act_a.push_back(int'(wr_addr));
            act_d.push_back(wr_data);
            wmem[int'(wr_addr)] = wr_data;
        end
    end

    task automatic chk(input bit ok, input string rq, input string what, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", rq, what, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic xfer_bits(input logic [7:0] tx, output logic [7:0] rx, input int nbits);
        rx = 8'h00;
        for (int i = 7; i >= 8 - nbits; i--) begin
            if (mode3) sck = 1'b0;
            mosi = tx[i];
            wait_clk(HALF);
            rx[i] = miso;
            sck = 1'b1;
            wait_clk(HALF);
            if (!mode3) sck = 1'b0;
        end
    endtask

    task automatic xfer(input logic [7:0] tx, output logic [7:0] rx);
        xfer_bits(tx, rx, 8);
    endtask

    task automatic cs_lo;
        sck = mode3;
        wait_clk(HALF);
        csn = 1'b0;
        wait_clk(HALF);
    endtask

    task automatic cs_hi;
        wait_clk(HALF);
        csn = 1'b1;
        wait_clk(2 * HALF);
    endtask

    task automatic cmd1(input logic [7:0] op);
        logic [7:0] d;
        cs_lo; xfer(op, d); cs_hi;
    endtask

    task automatic rdsr(output logic [7:0] v);
        logic [7:0] d;
        cs_lo; xfer(8'h05, d); xfer(8'h00, v); cs_hi;
    endtask

    task automatic chk_wr(input int a, input logic [7:0] dv, input string rq);
        if (act_ptr < act_a.size()) begin
            chk(act_a[act_ptr] == a, rq, "write address", act_a[act_ptr], a);
            chk(act_d[act_ptr] == dv, rq, "write data", int'(act_d[act_ptr]), int'(dv));
            act_ptr++;
        end else begin
            chk(1'b0, rq, "missing write", act_a.size(), act_ptr + 1);
        end
    endtask

    task automatic chk_no_more(input string rq);
        chk(act_a.size() == act_ptr, rq, "write count", act_a.size(), act_ptr);
        act_ptr = act_a.size();
    endtask

    initial begin
        logic [7:0] d, v;
        int oe0;
        csn = 1'b0; sck = 1'b0; mosi = 1'b0; holdn = 1'b1;
        wait_clk(5);
        rst = 1'b0;
        wait_clk(3);
        chk(miso_oe == 1'b0, "R1", "oe after reset", miso_oe, 0);
        chk(wr_en == 1'b0, "R1", "write strobe after reset", wr_en, 0);

        // select low since reset: opcode stream must be ignored
        oe0 = oe_cnt;
        xfer(8'h06, d); xfer(8'h05, d); xfer(8'h00, d);
        chk(oe_cnt == oe0, "R1", "oe with no select edge", oe_cnt - oe0, 0);
        csn = 1'b1; wait_clk(2 * HALF);
        rdsr(v); chk(v == 8'h00, "R1", "status after boot guard", v, 8'h00);

        cmd1(8'h06);
        rdsr(v); chk(v == 8'h02, "R3", "latch set", v, 8'h02);
        cs_lo; xfer(8'h05, d); xfer(8'h00, v); xfer(8'h00, d); cs_hi;
        chk(v == 8'h02 && d == 8'h02, "R4", "repeated status", d, 8'h02);
        cmd1(8'h04);
        rdsr(v); chk(v == 8'h00, "R3", "latch cleared", v, 8'h00);

        // write without latch
        cs_lo; xfer(8'h02, d); xfer(8'h01, d); xfer(8'h00, d); xfer(8'hAA, d); cs_hi;
        wait_clk(200); chk_no_more("R8");

        // basic page write
        cmd1(8'h06);
        cs_lo; xfer(8'h02, d); xfer(8'h01, d); xfer(8'h40, d);
        xfer(8'h11, d); xfer(8'h22, d); xfer(8'h33, d); cs_hi;
        wait_clk(100);
        rdsr(v); chk(v == 8'h03, "R10", "busy status", v, 8'h03);
        oe0 = oe_cnt;
        cs_lo; xfer(8'h03, d); xfer(8'h01, d); xfer(8'h40, d); xfer(8'h00, d); cs_hi;
        chk(oe_cnt == oe0, "R10", "read ignored while busy", oe_cnt - oe0, 0);
        wait_clk(TW + 200);
        rdsr(v); chk(v == 8'h00, "R10", "idle after busy", v, 8'h00);
        chk_wr(15'h140, 8'h11, "R6"); chk_wr(15'h141, 8'h22, "R6"); chk_wr(15'h142, 8'h33, "R6");
        chk_no_more("R6");

        // read back in mode 3
        mode3 = 1'b1;
        cs_lo; xfer(8'h03, d); xfer(8'h01, d); xfer(8'h40, d);
        xfer(8'h00, v); chk(v == 8'h11, "R2", "mode 3 read byte 0", v, 8'h11);
        xfer(8'h00, v); chk(v == 8'h22, "R5", "read increment", v, 8'h22);
        xfer(8'h00, v); chk(v == 8'h33, "R2", "mode 3 read byte 2", v, 8'h33);
        cs_hi;
        rdsr(v); chk(v == 8'h00, "R2", "mode 3 status", v, 8'h00);
        mode3 = 1'b0;

        // page wrap
        cmd1(8'h06);
        cs_lo; xfer(8'h02, d); xfer(8'h00, d); xfer(8'h7E, d);
        xfer(8'hA0, d); xfer(8'hA1, d); xfer(8'hA2, d); xfer(8'hA3, d); cs_hi;
        wait_clk(TW + 200);
        chk_wr(15'h040, 8'hA2, "R6"); chk_wr(15'h041, 8'hA3, "R6");
        chk_wr(15'h07E, 8'hA0, "R6"); chk_wr(15'h07F, 8'hA1, "R6");
        chk_no_more("R6");

        // deselect mid byte
        cmd1(8'h06);
        cs_lo; xfer(8'h02, d); xfer(8'h02, d); xfer(8'h00, d); xfer(8'h55, d);
        xfer_bits(8'hFF, d, 3); cs_hi;
        wait_clk(300); chk_no_more("R7");
        rdsr(v); chk(v == 8'h02, "R7", "latch kept after discard", v, 8'h02);
        // no data byte
        cs_lo; xfer(8'h02, d); xfer(8'h02, d); xfer(8'h00, d); cs_hi;
        wait_clk(300); chk_no_more("R7");

        // deselect while held
        cs_lo; xfer(8'h02, d); xfer(8'h03, d); xfer(8'h00, d); xfer(8'h66, d);
        wait_clk(2); holdn = 1'b0; wait_clk(2 * HALF);
        csn = 1'b1; wait_clk(2 * HALF); holdn = 1'b1; wait_clk(2 * HALF);
        wait_clk(300); chk_no_more("R12");
        rdsr(v); chk(v == 8'h02, "R12", "latch kept after held abort", v, 8'h02);
        cmd1(8'h04);

        // hold in the middle of a read
        cs_lo; xfer(8'h03, d); xfer(8'h01, d); xfer(8'h40, d);
        xfer(8'h00, v); chk(v == 8'h11, "R11", "read before hold", v, 8'h11);
        wait_clk(2); holdn = 1'b0; wait_clk(2 * HALF);
        chk(miso_oe == 1'b0, "R11", "oe while held", miso_oe, 0);
        mosi = 1'b1;
        sck = 1'b1; wait_clk(HALF); sck = 1'b0; wait_clk(HALF);
        sck = 1'b1; wait_clk(HALF); sck = 1'b0; wait_clk(HALF);
        holdn = 1'b1; wait_clk(HALF);
        xfer(8'h00, v); chk(v == 8'h22, "R11", "read after hold", v, 8'h22);
        chk(miso_oe == 1'b1, "R11", "oe after release", miso_oe, 1);
        cs_hi;

        // read wrap, top address bit ignored
        cs_lo; xfer(8'h03, d); xfer(8'hFF, d); xfer(8'hFF, d);
        xfer(8'h00, v); chk(v == model_rd(32'h7FFF), "R5", "read at top", v, model_rd(32'h7FFF));
        xfer(8'h00, v); chk(v == model_rd(0), "R5", "read wrap", v, model_rd(0));
        cs_hi;

        // unknown opcode
        oe0 = oe_cnt;
        cs_lo; xfer(8'h9F, d); xfer(8'h06, d); xfer(8'h05, d); xfer(8'h00, d); cs_hi;
        chk(oe_cnt == oe0, "R13", "oe after unknown opcode", oe_cnt - oe0, 0);
        rdsr(v); chk(v == 8'h00, "R13", "status after unknown opcode", v, 8'h00);

        // status write
        cs_lo; xfer(8'h01, d); xfer(8'h8C, d); cs_hi;
        wait_clk(300);
        rdsr(v); chk(v == 8'h00, "R8", "status write without latch", v, 8'h00);
        cmd1(8'h06);
        cs_lo; xfer(8'h01, d); xfer(8'h7C, d); cs_hi;
        wait_clk(TW + 200);
        rdsr(v); chk(v == 8'h0C, "R9", "stored protect field", v, 8'h0C);
        cmd1(8'h06);
        cs_lo; xfer(8'h01, d); xfer(8'h80, d); xfer(8'h0F, d); cs_hi;
        wait_clk(TW + 200);
        mode3 = 1'b1;
        rdsr(v); chk(v == 8'h80, "R9", "stored lock flag, later byte ignored", v, 8'h80);
        mode3 = 1'b0;
        chk_no_more("R9");

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(20 * 190000);
        total++;
        bad++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule